// File: doc/BRIEF.md
# Two-Channel Chained Ping-Pong DMA

This block moves 32-bit words from memory to a single peripheral location. Each of its two channels holds a source address, a destination address, a word count and a control word. Once started, a channel reads a word from the memory port and writes it to the peripheral port on the next cycle. It repeats this for as many words as its count holds, and only while the selected data-request line is high.

When a channel writes its final word, it can start its partner channel through a chain field in its control word. Two channels that name each other form a ping-pong pair. Software reloads the idle channel's registers while the other one streams, and the hand-over leaves no gap in the output word rate. A multi-start register launches any set of channels with one write. Each control word shows a live busy flag. A completion pulse per channel can be silenced with a quiet bit.

Top module: `pingpong_dma`

## Requirements
- R1: After reset, every channel register reads zero, busy is clear, and no memory read or peripheral write takes place.
- R2: Channel 0 registers sit at 0x00 (source), 0x04 (destination), 0x08 (count, which reads back the remaining count) and 0x0C / 0x10 (control, with and without start). Channel 1 uses the same offsets plus 0x40. Control reads back as written, except bit 24.
- R3: Control fields are: bit 0 enable, bits 3:2 size (value 2 means words; stored only), bit 4 source increment, bit 5 destination increment, bits 14:11 chain target, bits 20:15 request select, bit 21 quiet, and bit 24 read-only busy.
- R4: A control write at offset 0x10 changes the configuration and starts nothing. A control write at offset 0x0C with bit 0 set starts the channel: it reloads the working source, destination and count from the programmed values.
- R5: A memory read issued at working address A in cycle t is followed by a peripheral write of the returned word in cycle t+1. The source address advances by 4 only with bit 4 set, and the destination by 4 only with bit 5 set. The count drops by one per word. One word is in flight at a time, so words go out every second cycle at most.
- R6: A channel issues reads only while dreq[select] is high. A select value of NREQ or more means the channel is never held back.
- R7: Busy (control bit 24) is set while the remaining count is non-zero or the channel's last word is still in flight.
- R8: In the cycle a channel writes its final word, the channel named in its chain field is started if it is enabled. A channel that names itself, or a channel number above 1, chains nothing. The partner's first read comes one cycle later, which keeps the two-cycle word spacing unbroken.
- R9: A write to offset 0x430 starts every enabled channel whose bit (bit 0 or bit 1) is set. Disabled channels ignore it.
- R10: done_irq[c] pulses in the cycle of channel c's final write, unless its quiet bit is set.
- R11: When both channels are ready in the same cycle, service alternates between them.
- R12: Clearing enable pauses a channel and keeps its remaining count. Setting enable again resumes it. Starting a channel with count zero moves no data, raises no pulse and chains nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 12 | Register byte address for reads and writes |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr (combinational) |
| dreq | input | NREQ | Data-request lines |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | AW | Memory read address |
| mem_rd_data | input | 32 | Memory read data, valid the cycle after mem_rd_en |
| per_wr_en | output | 1 | Peripheral write strobe |
| per_wr_addr | output | AW | Peripheral write address |
| per_wr_data | output | 32 | Peripheral write data |
| done_irq | output | 2 | Per-channel completion pulse |

## Verification
The bench builds the block with CW=8 and NREQ=2. With only two request lines, select values 2 and 3 fall past the last line and run unpaced, so the bench can use both paced and unpaced channels. The narrow count keeps every run to a few words. The checks cover the chained hand-over, round-robin alternation, pause and resume, and the zero-count start within a short run.

// File: rtl/pingpong_dma.sv
module pingpong_dma #(
  parameter int AW   = 32,
  parameter int CW   = 16,
  parameter int NREQ = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_wr,
  input  logic [11:0]     cfg_addr,
  input  logic [31:0]     cfg_wdata,
  output logic [31:0]     cfg_rdata,
  input  logic [NREQ-1:0] dreq,
  output logic            mem_rd_en,
  output logic [AW-1:0]   mem_rd_addr,
  input  logic [31:0]     mem_rd_data,
  output logic            per_wr_en,
  output logic [AW-1:0]   per_wr_addr,
  output logic [31:0]     per_wr_data,
  output logic [1:0]      done_irq
);

  localparam int B_EN = 0, B_RINC = 4, B_WINC = 5, B_QUIET = 21, B_BUSY = 24;
  localparam logic [11:0] MULTI_OFS = 12'h430;
  localparam logic [AW-1:0] STEP = AW'(4);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [AW-1:0] rd_prog [2];
  logic [AW-1:0] wr_prog [2];
  logic [AW-1:0] rd_cur  [2];
  logic [AW-1:0] wr_cur  [2];
  logic [CW-1:0] cnt_prog [2];
  logic [CW-1:0] cnt_cur  [2];
  logic [31:0]   ctrl [2];
  logic [5:0]    sel  [2];

  logic          infl, infl_ch, infl_last, last_ch, gnt_ch;
  logic [AW-1:0] infl_waddr;
  logic [1:0]    trig, want, busy, done, en_next, req_ok, ctl_wr;

  wire       multi_wr = cfg_wr && (cfg_addr == MULTI_OFS);
  wire [5:0] ofs      = cfg_addr[5:0];

  assign done = {infl && infl_last && infl_ch, infl && infl_last && !infl_ch};

  always_comb begin
    for (int c = 0; c < 2; c++) begin
      ctl_wr[c]  = cfg_wr && (cfg_addr[11:6] == 6'(c)) && (ofs == 6'h0C || ofs == 6'h10);
      en_next[c] = ctl_wr[c] ? cfg_wdata[B_EN] : ctrl[c][B_EN];
      trig[c]    = en_next[c] &&
                   ((ctl_wr[c] && ofs == 6'h0C) ||
                    (multi_wr && cfg_wdata[c]) ||
                    (done[1-c] && ctrl[1-c][14:11] == 4'(c)));
      sel[c]     = ctrl[c][20:15];
      req_ok[c]  = 1'b1;
      for (int r = 0; r < NREQ; r++)
        if (sel[c] == 6'(r)) req_ok[c] = dreq[r];
      busy[c] = (cnt_cur[c] != '0) || (infl && infl_ch == 1'(c));
      want[c] = (cnt_cur[c] != '0) && ctrl[c][B_EN] && req_ok[c] && !infl && !trig[c];
    end
  end

  assign gnt_ch      = (want == 2'b11) ? ~last_ch : want[1];
  assign mem_rd_en   = |want;
  assign mem_rd_addr = rd_cur[gnt_ch];
  assign per_wr_en   = infl;
  assign per_wr_addr = infl_waddr;
  assign per_wr_data = mem_rd_data;
  assign done_irq    = done & ~{ctrl[1][B_QUIET], ctrl[0][B_QUIET]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      infl       <= 1'b0;
      infl_ch    <= 1'b0;
      infl_last  <= 1'b0;
      infl_waddr <= '0;
      last_ch    <= 1'b1;
      for (int c = 0; c < 2; c++) begin
        rd_prog[c]  <= '0;
        wr_prog[c]  <= '0;
        rd_cur[c]   <= '0;
        wr_cur[c]   <= '0;
        cnt_prog[c] <= '0;
        cnt_cur[c]  <= '0;
        ctrl[c]     <= '0;
      end
    end else begin
      infl <= mem_rd_en;
      if (mem_rd_en) begin
        infl_ch    <= gnt_ch;
        infl_last  <= (cnt_cur[gnt_ch] == ONE);
        infl_waddr <= wr_cur[gnt_ch];
        last_ch    <= gnt_ch;
      end
      for (int c = 0; c < 2; c++) begin
        if (cfg_wr && cfg_addr[11:6] == 6'(c)) begin
          case (ofs)
            6'h00:        rd_prog[c]  <= cfg_wdata[AW-1:0];
            6'h04:        wr_prog[c]  <= cfg_wdata[AW-1:0];
            6'h08:        cnt_prog[c] <= cfg_wdata[CW-1:0];
            6'h0C, 6'h10: ctrl[c]     <= cfg_wdata & ~(32'd1 << B_BUSY);
            default: ;
          endcase
        end
        if (trig[c]) begin
          rd_cur[c]  <= rd_prog[c];
          wr_cur[c]  <= wr_prog[c];
          cnt_cur[c] <= cnt_prog[c];
        end else if (mem_rd_en && gnt_ch == 1'(c)) begin
          cnt_cur[c] <= cnt_cur[c] - ONE;
          if (ctrl[c][B_RINC]) rd_cur[c] <= rd_cur[c] + STEP;
          if (ctrl[c][B_WINC]) wr_cur[c] <= wr_cur[c] + STEP;
        end
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr[11:7] == 5'd0) begin
      case (ofs)
        6'h00:        cfg_rdata = 32'(rd_prog[cfg_addr[6]]);
        6'h04:        cfg_rdata = 32'(wr_prog[cfg_addr[6]]);
        6'h08:        cfg_rdata = 32'(cnt_cur[cfg_addr[6]]);
        6'h0C, 6'h10: cfg_rdata = ctrl[cfg_addr[6]] | (32'(busy[cfg_addr[6]]) << B_BUSY);
        default:      cfg_rdata = '0;
      endcase
    end
  end

  assert_rd_then_wr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> per_wr_en);
  assert_single_flight_R5: assert property (@(posedge clk) disable iff (!rst_n)
    per_wr_en |-> !mem_rd_en);
  assert_cnt_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && !gnt_ch && !trig[0]) |=> cnt_cur[0] == $past(cnt_cur[0]) - ONE);
  assert_paced_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && sel[gnt_ch] < 6'(NREQ)) |-> dreq[sel[gnt_ch][$clog2(NREQ > 1 ? NREQ : 2)-1:0]]);
  assert_idle_no_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy[0] && !busy[1]) |-> !mem_rd_en);
  assert_chain_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done[0] && ctrl[0][14:11] == 4'd1 && en_next[1]) |=> cnt_cur[1] == $past(cnt_prog[1]));
  assert_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[0][B_QUIET] || !per_wr_en) |-> !done_irq[0]);
  assert_irq_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(done_irq));

endmodule

// File: tb/tb_pingpong_dma.sv
module tb_pingpong_dma;
  localparam int CLK_NS = 10;
  localparam int AW = 32, CW = 8, NREQ = 2;

  logic clk = 1'b0, rst_n = 1'b0, cfg_wr = 1'b0;
  logic [11:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata, mem_rd_data = '0, per_wr_data;
  logic [NREQ-1:0] dreq = '0;
  logic mem_rd_en, per_wr_en;
  logic [AW-1:0] mem_rd_addr, per_wr_addr;
  logic [1:0] done_irq;

  pingpong_dma #(.AW(AW), .CW(CW), .NREQ(NREQ)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .dreq(dreq),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .per_wr_en(per_wr_en), .per_wr_addr(per_wr_addr), .per_wr_data(per_wr_data),
    .done_irq(done_irq));

  always #(CLK_NS/2) clk = ~clk;

  function automatic logic [31:0] pat(input logic [31:0] a);
    return a ^ 32'h5A5A_0000;
  endfunction

  function automatic logic [31:0] cw(input bit en, input bit rinc, input bit winc,
                                     input int chain, input int rsel, input bit quiet);
    return 32'(en) | (32'd2 << 2) | (32'(rinc) << 4) | (32'(winc) << 5) |
           (32'(chain) << 11) | (32'(rsel) << 15) | (32'(quiet) << 21);
  endfunction

  always @(posedge clk) if (mem_rd_en) mem_rd_data <= pat(mem_rd_addr);

  int n_chk = 0, n_fail = 0, cyc = 0, n_wr = 0, n_rd_total = 0;
  int irq0 = 0, irq1 = 0;
  logic [31:0] log_a [64];
  logic [31:0] log_d [64];
  int          log_c [64];

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && mem_rd_en) n_rd_total <= n_rd_total + 1;
    if (rst_n && per_wr_en) begin
      log_a[n_wr % 64] <= per_wr_addr;
      log_d[n_wr % 64] <= per_wr_data;
      log_c[n_wr % 64] <= cyc;
      n_wr <= n_wr + 1;
    end
    if (done_irq[0]) irq0 <= irq0 + 1;
    if (done_irq[1]) irq1 <= irq1 + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    cfg_addr = a;
    #1;
    d = cfg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_wr(input int base, input int n);
    for (int i = 0; i < 300 && (n_wr - base) < n; i++) @(negedge clk);
    idle(4);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int a = 0; a < 5; a++) begin
      rd(12'(a * 4), v);        chk("R1 ch0 reg", v, 0);
      rd(12'(a * 4 + 'h40), v); chk("R1 ch1 reg", v, 0);
    end
    chk("R1 no transfers", 32'(n_wr + n_rd_total), 0);
  endtask

  task automatic t_regmap;
    logic [31:0] v;
    int base = n_wr;
    wr(12'h040, 32'h1234_5678);
    wr(12'h044, 32'h8765_4320);
    wr(12'h048, 32'h5A);
    wr(12'h050, 32'h0121_8839);
    rd(12'h040, v); chk("R2 ch1 src", v, 32'h1234_5678);
    rd(12'h044, v); chk("R2 ch1 dst", v, 32'h8765_4320);
    rd(12'h050, v); chk("R3 ctrl fields busy masked", v, 32'h0021_8839);
    rd(12'h04C, v); chk("R2 ctrl alias", v, 32'h0021_8839);
    rd(12'h048, v); chk("R4 plain ctrl write no start", v, 0);
    rd(12'h004, v); chk("R2 ch0 untouched", v, 0);
    idle(6);
    chk("R4 no writes after plain ctrl", 32'(n_wr - base), 0);
  endtask

  task automatic t_basic;
    logic [31:0] v;
    int base, i0 = irq0;
    wr(12'h000, 32'h1000); wr(12'h004, 32'h8000); wr(12'h008, 4);
    base = n_wr;
    wr(12'h00C, cw(1, 1, 0, 0, 3, 0));
    rd(12'h00C, v); chk("R7 busy while running", v[24], 1);
    wait_wr(base, 4);
    chk("R5 word count", 32'(n_wr - base), 4);
    for (int i = 0; i < 4; i++) begin
      chk("R5 dst fixed", log_a[(base+i)%64], 32'h8000);
      chk("R5 src incr data", log_d[(base+i)%64], pat(32'h1000 + 32'(4*i)));
      if (i > 0) chk("R5 spacing", 32'(log_c[(base+i)%64] - log_c[(base+i-1)%64]), 2);
    end
    rd(12'h00C, v); chk("R7 busy clear at end", v[24], 0);
    rd(12'h008, v); chk("R5 count at zero", v, 0);
    chk("R10 one completion pulse", 32'(irq0 - i0), 1);
  endtask

  task automatic t_incr_modes;
    int base;
    wr(12'h000, 32'h4000); wr(12'h004, 32'hC000); wr(12'h008, 3);
    base = n_wr;
    wr(12'h00C, cw(1, 0, 1, 0, 2, 0));
    wait_wr(base, 3);
    chk("R5 count", 32'(n_wr - base), 3);
    for (int i = 0; i < 3; i++) begin
      chk("R5 dst incr", log_a[(base+i)%64], 32'hC000 + 32'(4*i));
      chk("R5 src fixed", log_d[(base+i)%64], pat(32'h4000));
    end
  endtask

  task automatic t_pacing;
    logic [31:0] v;
    int base;
    dreq = '0;
    wr(12'h000, 32'h5000); wr(12'h004, 32'hD000); wr(12'h008, 5);
    base = n_wr;
    wr(12'h00C, cw(1, 1, 0, 0, 0, 0));
    idle(10);
    chk("R6 held without request", 32'(n_wr - base), 0);
    rd(12'h008, v); chk("R6 count kept", v, 5);
    dreq[0] = 1'b1;
    wait_wr(base, 5);
    chk("R6 runs with request", 32'(n_wr - base), 5);
    chk("R6 last data", log_d[(base+4)%64], pat(32'h5010));
    dreq = '0;
  endtask

  task automatic t_pause_zero;
    logic [31:0] v;
    int base, i1 = irq1;
    wr(12'h000, 32'h6000); wr(12'h004, 32'hE000); wr(12'h008, 4);
    base = n_wr;
    wr(12'h00C, cw(1, 1, 0, 0, 1, 0));
    wr(12'h010, cw(0, 1, 0, 0, 1, 0));
    dreq[1] = 1'b1;
    idle(10);
    chk("R12 paused no writes", 32'(n_wr - base), 0);
    rd(12'h008, v); chk("R12 count kept", v, 4);
    rd(12'h010, v); chk("R12 busy kept", v[24], 1);
    wr(12'h010, cw(1, 1, 0, 0, 1, 0));
    wait_wr(base, 4);
    chk("R12 resumed", 32'(n_wr - base), 4);
    chk("R12 resume data", log_d[base%64], pat(32'h6000));
    dreq = '0;
    wr(12'h048, 0);
    base = n_wr;
    wr(12'h04C, cw(1, 1, 0, 0, 3, 0));
    idle(8);
    chk("R12 zero count no data", 32'(n_wr - base), 0);
    chk("R12 zero count no pulse", 32'(irq1 - i1), 0);
    rd(12'h04C, v); chk("R12 zero count idle", v[24], 0);
  endtask

  task automatic t_chain;
    logic [31:0] v;
    int base, i0 = irq0, i1 = irq1;
    wr(12'h000, 32'h1100); wr(12'h004, 32'h9000); wr(12'h008, 3);
    wr(12'h010, cw(1, 1, 0, 1, 3, 0));
    wr(12'h040, 32'h1200); wr(12'h044, 32'h9000); wr(12'h048, 3);
    wr(12'h050, cw(1, 1, 0, 1, 3, 1));
    base = n_wr;
    wr(12'h430, 32'h1);
    wait_wr(base, 6);
    idle(12);
    chk("R8 six words no self restart", 32'(n_wr - base), 6);
    for (int i = 0; i < 6; i++) begin
      chk("R8 data order", log_d[(base+i)%64],
          pat((i < 3 ? 32'h1100 : 32'h1200) + 32'(4*(i%3))));
      if (i > 0) chk("R8 gapless", 32'(log_c[(base+i)%64] - log_c[(base+i-1)%64]), 2);
    end
    chk("R10 ch0 pulse", 32'(irq0 - i0), 1);
    chk("R10 ch1 quiet", 32'(irq1 - i1), 0);
    rd(12'h00C, v); chk("R7 ch0 idle", v[24], 0);
    rd(12'h04C, v); chk("R7 ch1 idle", v[24], 0);
  endtask

  task automatic t_multi_disabled;
    logic [31:0] v;
    int base;
    wr(12'h048, 5);
    wr(12'h050, cw(0, 1, 0, 1, 3, 0));
    base = n_wr;
    wr(12'h430, 32'h2);
    idle(8);
    chk("R9 disabled ignores start", 32'(n_wr - base), 0);
    rd(12'h04C, v); chk("R9 disabled not busy", v[24], 0);
  endtask

  task automatic t_round_robin;
    int base;
    wr(12'h000, 32'h2000); wr(12'h004, 32'hA000); wr(12'h008, 3);
    wr(12'h010, cw(1, 1, 0, 0, 3, 0));
    wr(12'h040, 32'h3000); wr(12'h044, 32'hB000); wr(12'h048, 3);
    wr(12'h050, cw(1, 1, 0, 1, 3, 0));
    base = n_wr;
    wr(12'h430, 32'h3);
    wait_wr(base, 6);
    chk("R9 both started", 32'(n_wr - base), 6);
    for (int i = 1; i < 6; i++)
      chk("R11 alternation", 32'(log_a[(base+i)%64] != log_a[(base+i-1)%64]), 1);
  endtask

  initial begin
    #(CLK_NS * 150000);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_regmap();
    t_basic();
    t_incr_modes();
    t_pacing();
    t_pause_zero();
    t_chain();
    t_multi_disabled();
    t_round_robin();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule